// File: doc/BRIEF.md
# Direct-Mapped Write-Back Second-Level Cache Controller

This block manages an external direct-mapped second-level cache that sits between a 32-bit processor bus and main memory. The tag store is kept inside the block. The cache data lives in an external single-port SRAM that the block addresses one word at a time. Each processor request is looked up with a single tag compare. A read hit is served as a four-word line burst from the data SRAM. A write hit changes only the cached word and marks the line dirty. Misses, and addresses above the cacheable range, are handed to a main-memory port that moves one word per handshake.

Every tag word is `TAG_W` bits wide, and write-back operation takes one of those bits as the dirty flag. The address tag therefore uses `TAG_W-1` bits, and the cacheable range is half of what the full word could cover. A read miss that displaces a dirty line first copies the old line out to memory, then fills the new line. Each fill word goes to the processor and into the data SRAM in the same cycle. A write miss goes straight to memory and allocates nothing. Reset and the flush input both start a sweep that invalidates one entry per cycle, and the block does not accept requests until the sweep ends.

Top module: `l2wb_ctrl`

## Requirements
- R1: Byte address bits [4+IDX_W-1:4] select the tag entry and the next TAG_W-1 bits form the compared tag. An address with any bit set above those is non-cacheable.
- R2: A read hit returns the four words of the line in order 0,1,2,3. `cpu_rdy` is high in cycles 2, 3, 4 and 5, counting the cycle after the accepting edge as cycle 1. No memory request is made.
- R3: A write hit writes word addr[3:2] of the line into the data SRAM, sets the dirty flag and pulses `cpu_rdy` in cycle 2. No memory request is made.
- R4: A read miss whose entry holds a valid dirty line first writes the old line to memory, words 0 to 3 in order. Each address is rebuilt from the stored tag and the index, and all of these writes come before the first fill read.
- R5: A cacheable read miss reads the line from memory, words 0 to 3 in order. Each word is given to the processor with `cpu_rdy` in the same cycle it is written into the data SRAM. The entry then holds the new tag, valid and clean.
- R6: A read miss to a clean or invalid entry issues no memory write.
- R7: A write miss performs exactly one memory write with the processor's address and data. The cache entry is left unchanged, so no line is allocated.
- R8: A non-cacheable read or write always goes to memory, with four word reads for a read and one write for a write. The cache entry at the same index is left untouched.
- R9: After reset is released, and after a flush is taken, `ctl_ready` stays low for exactly 2^IDX_W cycles while every entry is invalidated. Dirty contents are discarded without a write-back.
- R10: A flush and a request that arrive in the same idle cycle take the flush first, and the request is dropped. A request made while `ctl_ready` is low is ignored.
- R11: `mem_req` stays high with `mem_addr`, `mem_we` and `mem_wdata` stable until `mem_ack`. Exactly one word moves per acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, starts the invalidate sweep |
| flush | input | 1 | Invalidate all entries, taken when idle |
| cpu_req | input | 1 | Request strobe, accepted while `ctl_ready` is high |
| cpu_we | input | 1 | 1 = single-word write, 0 = four-word line read |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdy | output | 1 | One word completed this cycle |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_rdy` |
| ctl_ready | output | 1 | Controller idle and able to accept a request |
| sram_addr | output | IDX_W+2 | Data SRAM word address {index, word} |
| sram_we | output | 1 | Data SRAM write enable |
| sram_wdata | output | DATA_W | Data SRAM write data |
| sram_rdata | input | DATA_W | Data SRAM read data, combinational from `sram_addr` |
| mem_req | output | 1 | Main-memory word request |
| mem_we | output | 1 | Main-memory write |
| mem_addr | output | ADDR_W | Main-memory byte address |
| mem_wdata | output | DATA_W | Main-memory write data |
| mem_ack | input | 1 | Main memory completed the requested word |
| mem_rdata | input | DATA_W | Main-memory read data, valid with `mem_ack` |

## Verification
The bench builds the controller with ADDR_W=16, IDX_W=4 and TAG_W=4. That gives 16 entries, a 3-bit tag and a cacheable limit of 0x800. With these values a short address set covers every case. Several tags compete for the same few entries, so dirty evictions, clean refills, hits and write misses all occur within a few dozen accesses. Addresses at 0x800 and above alias the same entries without being cacheable. The invalidate sweep is short enough that its length can be counted exactly, after reset and after a flush.

// File: rtl/l2wb_pkg.sv
package l2wb_pkg;

    localparam int LINE_OFS   = 4;   // byte offset bits within a 16-byte line
    localparam int LINE_WORDS = 4;

    typedef enum logic [2:0] {
        ST_CLEAR,
        ST_IDLE,
        ST_LOOKUP,
        ST_HIT_RD,
        ST_HIT_WR,
        ST_WBACK,
        ST_FILL,
        ST_MEM_WR
    } l2_state_e;

    typedef enum logic [1:0] {
        LK_HIT,
        LK_MISS_CLEAN,
        LK_MISS_DIRTY,
        LK_UNCACHED
    } l2_lookup_e;

    function automatic logic last_word(input logic [1:0] w);
        return w == 2'(LINE_WORDS - 1);
    endfunction

endpackage

// File: rtl/l2wb_tag_store.sv
module l2wb_tag_store #(
    parameter int IDX_W  = 10,
    parameter int ATAG_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic              rd_dirty,
    output logic [ATAG_W-1:0] rd_tag,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_valid,
    input  logic              wr_dirty,
    input  logic [ATAG_W-1:0] wr_tag
);
    localparam int DEPTH = 1 << IDX_W;

    // One tag word per entry: ATAG_W address bits plus the dirty bit, with a separate valid flag.
    logic [ATAG_W-1:0] tag_q   [DEPTH];
    logic [DEPTH-1:0]  valid_q;
    logic [DEPTH-1:0]  dirty_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]   <= wr_tag;
            valid_q[wr_idx] <= wr_valid;
            dirty_q[wr_idx] <= wr_dirty;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];

    // R9: an invalidating write leaves that entry invalid
    a_r9_clear_sticks: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_valid) |=> !valid_q[$past(wr_idx)]);

endmodule

// File: rtl/l2wb_tag_cmp.sv
module l2wb_tag_cmp
    import l2wb_pkg::*;
#(
    parameter int LINE_W = 28,
    parameter int IDX_W  = 10,
    parameter int ATAG_W = 7
) (
    input  logic [LINE_W-1:0] line_addr,
    input  logic              ent_valid,
    input  logic              ent_dirty,
    input  logic [ATAG_W-1:0] ent_tag,
    output logic [IDX_W-1:0]  idx,
    output logic [ATAG_W-1:0] tag,
    output logic              cacheable,
    output l2_lookup_e        look
);
    assign idx = line_addr[IDX_W-1:0];
    assign tag = line_addr[IDX_W +: ATAG_W];

    generate
        if (LINE_W > IDX_W + ATAG_W) begin : g_limit
            assign cacheable = ~|line_addr[LINE_W-1:IDX_W+ATAG_W];
        end else begin : g_full
            assign cacheable = 1'b1;
        end
    endgenerate

    always_comb begin
        if (!cacheable)                       look = LK_UNCACHED;
        else if (ent_valid && ent_tag == tag) look = LK_HIT;
        else if (ent_valid && ent_dirty)      look = LK_MISS_DIRTY;
        else                                  look = LK_MISS_CLEAN;
    end

endmodule

// File: rtl/l2wb_ctrl.sv
module l2wb_ctrl
    import l2wb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 10,
    parameter int TAG_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_rdy,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              ctl_ready,
    output logic [IDX_W+1:0]  sram_addr,
    output logic              sram_we,
    output logic [DATA_W-1:0] sram_wdata,
    input  logic [DATA_W-1:0] sram_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int ATAG_W = TAG_W - 1;               // dirty flag takes one tag bit
    localparam int LINE_W = ADDR_W - LINE_OFS;
    localparam int CW     = ATAG_W + IDX_W + LINE_OFS;

    l2_state_e         state_q;
    logic [ADDR_W-1:0] addr_q;
    logic              we_q;
    logic [DATA_W-1:0] wdata_q;
    logic [1:0]        word_q;
    logic [IDX_W-1:0]  clr_q;

    logic              ent_valid, ent_dirty;
    logic [ATAG_W-1:0] ent_tag;
    logic [IDX_W-1:0]  line_idx;
    logic [ATAG_W-1:0] line_tag;
    logic              cacheable;
    l2_lookup_e        look;

    logic              tw_en, tw_valid, tw_dirty;
    logic [IDX_W-1:0]  tw_idx;
    logic [ATAG_W-1:0] tw_tag;
    logic [ADDR_W-1:0] wb_addr, fill_addr;

    l2wb_tag_store #(.IDX_W(IDX_W), .ATAG_W(ATAG_W)) u_tags (
        .clk(clk), .rst(rst),
        .rd_idx(line_idx), .rd_valid(ent_valid), .rd_dirty(ent_dirty), .rd_tag(ent_tag),
        .wr_en(tw_en), .wr_idx(tw_idx), .wr_valid(tw_valid), .wr_dirty(tw_dirty), .wr_tag(tw_tag)
    );

    l2wb_tag_cmp #(.LINE_W(LINE_W), .IDX_W(IDX_W), .ATAG_W(ATAG_W)) u_cmp (
        .line_addr(addr_q[ADDR_W-1:LINE_OFS]),
        .ent_valid(ent_valid), .ent_dirty(ent_dirty), .ent_tag(ent_tag),
        .idx(line_idx), .tag(line_tag), .cacheable(cacheable), .look(look)
    );

    always_comb begin
        wb_addr          = '0;
        wb_addr[CW-1:0]  = {ent_tag, line_idx, word_q, 2'b00};
        fill_addr        = {addr_q[ADDR_W-1:LINE_OFS], word_q, 2'b00};
    end

    // Tag store write port: sweep, write-hit dirty mark, fill completion
    always_comb begin
        tw_en    = 1'b0;
        tw_idx   = line_idx;
        tw_valid = 1'b1;
        tw_dirty = 1'b0;
        tw_tag   = line_tag;
        case (state_q)
            ST_CLEAR: begin
                tw_en    = 1'b1;
                tw_idx   = clr_q;
                tw_valid = 1'b0;
            end
            ST_HIT_WR: begin
                tw_en    = 1'b1;
                tw_dirty = 1'b1;
            end
            ST_FILL: tw_en = mem_ack && cacheable && last_word(word_q);
            default: ;
        endcase
    end

    // Datapath outputs
    always_comb begin
        ctl_ready  = state_q == ST_IDLE;
        cpu_rdy    = 1'b0;
        cpu_rdata  = mem_rdata;
        sram_addr  = {line_idx, word_q};
        sram_we    = 1'b0;
        sram_wdata = mem_rdata;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = fill_addr;
        mem_wdata  = wdata_q;
        case (state_q)
            ST_HIT_RD: begin
                cpu_rdy   = 1'b1;
                cpu_rdata = sram_rdata;
            end
            ST_HIT_WR: begin
                cpu_rdy    = 1'b1;
                sram_addr  = {line_idx, addr_q[3:2]};
                sram_we    = 1'b1;
                sram_wdata = wdata_q;
            end
            ST_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = wb_addr;
                mem_wdata = sram_rdata;
            end
            ST_FILL: begin
                mem_req = 1'b1;
                cpu_rdy = mem_ack;
                sram_we = mem_ack && cacheable;
            end
            ST_MEM_WR: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = addr_q;
                cpu_rdy  = mem_ack;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_CLEAR;
            clr_q   <= '0;
            word_q  <= '0;
            addr_q  <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
        end else begin
            case (state_q)
                ST_CLEAR: begin
                    clr_q <= clr_q + 1'b1;
                    if (&clr_q) state_q <= ST_IDLE;
                end
                ST_IDLE: begin
                    if (flush) begin
                        clr_q   <= '0;
                        state_q <= ST_CLEAR;
                    end else if (cpu_req) begin
                        addr_q  <= cpu_addr;
                        we_q    <= cpu_we;
                        wdata_q <= cpu_wdata;
                        state_q <= ST_LOOKUP;
                    end
                end
                ST_LOOKUP: begin
                    word_q <= '0;
                    if (we_q)                    state_q <= (look == LK_HIT) ? ST_HIT_WR : ST_MEM_WR;
                    else if (look == LK_HIT)     state_q <= ST_HIT_RD;
                    else if (look == LK_MISS_DIRTY) state_q <= ST_WBACK;
                    else                         state_q <= ST_FILL;
                end
                ST_HIT_RD: begin
                    word_q <= word_q + 1'b1;
                    if (last_word(word_q)) state_q <= ST_IDLE;
                end
                ST_HIT_WR: state_q <= ST_IDLE;
                ST_WBACK: if (mem_ack) begin
                    word_q <= word_q + 1'b1;
                    if (last_word(word_q)) state_q <= ST_FILL;
                end
                ST_FILL: if (mem_ack) begin
                    word_q <= word_q + 1'b1;
                    if (last_word(word_q)) state_q <= ST_IDLE;
                end
                ST_MEM_WR: if (mem_ack) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R2 / R3: hits never touch main memory
    a_r2_hit_no_mem: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HIT_RD || state_q == ST_HIT_WR) |-> !mem_req);

    // R11: request held stable until acknowledged
    a_r11_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R7: a write forwarded to memory never writes the data SRAM
    a_r7_no_alloc: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_MEM_WR) |-> !sram_we);

    // R10: completions only occur while not accepting requests
    a_r10_busy_rdy: assert property (@(posedge clk) disable iff (rst)
        cpu_rdy |-> !ctl_ready);

    // R4: the fill after a write-back starts only on the last write-back acknowledge
    a_r4_wb_before_fill: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FILL && $past(state_q) == ST_WBACK) |-> ($past(mem_ack) && $past(mem_we)));

endmodule

// File: tb/test_l2wb_ctrl.sv
module test_l2wb_ctrl;
    localparam int AW = 16, DW = 32, IW = 4, TW = 4;
    localparam int AT = TW - 1;
    localparam int N  = 1 << IW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic flush = 1'b0, cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic cpu_rdy, ctl_ready, sram_we, mem_req, mem_we;
    logic [DW-1:0] cpu_rdata, sram_wdata, sram_rdata, mem_wdata;
    logic [IW+1:0] sram_addr;
    logic [AW-1:0] mem_addr;
    logic mem_ack = 1'b0;
    logic [DW-1:0] mem_rdata = '0;

    always #10 clk = ~clk;

    l2wb_ctrl #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW), .TAG_W(TW)) i_l2wb_ctrl (
        .clk(clk), .rst(rst), .flush(flush), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdy(cpu_rdy), .cpu_rdata(cpu_rdata),
        .ctl_ready(ctl_ready), .sram_addr(sram_addr), .sram_we(sram_we), .sram_wdata(sram_wdata),
        .sram_rdata(sram_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata));

    // external data SRAM (asynchronous read)
    logic [DW-1:0] sram [4*N];
    assign sram_rdata = sram[sram_addr];
    always @(posedge clk) if (sram_we) sram[sram_addr] <= sram_wdata;

    // main memory model and traffic log
    logic [DW-1:0] mem_q [int];
    logic [DW-1:0] ref_mem [int];
    int wlog_a[$];
    logic [DW-1:0] wlog_d[$];
    bit kind_q[$];
    int mwait = 0;

    function automatic logic [DW-1:0] dflt(int w);
        return (w * 32'h0100_0193) ^ 32'hC0DE_0000;
    endfunction
    function automatic logic [DW-1:0] mget(int a);
        return mem_q.exists(a >> 2) ? mem_q[a >> 2] : dflt(a >> 2);
    endfunction
    function automatic logic [DW-1:0] rget(int a);
        return ref_mem.exists(a >> 2) ? ref_mem[a >> 2] : dflt(a >> 2);
    endfunction

    always @(posedge clk) begin
        #1;
        if (mem_ack) mem_ack = 1'b0;
        else if (mem_req && !rst) begin
            mwait++;
            if (mwait == 2) begin
                mwait = 0;
                mem_ack = 1'b1;
                if (mem_we) begin
                    mem_q[int'(mem_addr) >> 2] = mem_wdata;
                    wlog_a.push_back(int'(mem_addr));
                    wlog_d.push_back(mem_wdata);
                    kind_q.push_back(1'b1);
                end else begin
                    mem_rdata = mget(int'(mem_addr));
                    kind_q.push_back(1'b0);
                end
            end
        end
    end

    // reference cache state
    bit rv[N], rdirty[N];
    int rt[N];
    logic [DW-1:0] rdat[4*N];

    int n_chk = 0, n_fail = 0;

    task automatic chk(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic access(bit we, int a, logic [DW-1:0] wd, string req);
        int idx = (a >> 4) & (N - 1);
        int tg  = a >> (4 + IW);
        bit cach = tg < (1 << AT);
        bit hit = cach && rv[idx] && rt[idx] == tg;
        logic [DW-1:0] exp_d[4];
        logic [DW-1:0] got[4];
        int at[4];
        int exp_wa[$];
        logic [DW-1:0] exp_wd[$];
        int exp_rd = 0, nrdy = 0, cyc = 0, rc = 0;
        int need = we ? 1 : 4;
        if (!we) begin
            if (hit) begin
                for (int w = 0; w < 4; w++) exp_d[w] = rdat[idx*4+w];
            end else begin
                if (cach && rv[idx] && rdirty[idx])
                    for (int w = 0; w < 4; w++) begin
                        int wa = (rt[idx] << (4 + IW)) | (idx << 4) | (w << 2);
                        exp_wa.push_back(wa);
                        exp_wd.push_back(rdat[idx*4+w]);
                        ref_mem[wa >> 2] = rdat[idx*4+w];
                    end
                for (int w = 0; w < 4; w++) exp_d[w] = rget((a & ~15) | (w << 2));
                exp_rd = 4;
                if (cach) begin
                    rv[idx] = 1; rt[idx] = tg; rdirty[idx] = 0;
                    for (int w = 0; w < 4; w++) rdat[idx*4+w] = exp_d[w];
                end
            end
        end else begin
            if (hit) begin
                rdat[idx*4 + ((a >> 2) & 3)] = wd;
                rdirty[idx] = 1;
            end else begin
                ref_mem[a >> 2] = wd;
                exp_wa.push_back(a);
                exp_wd.push_back(wd);
            end
        end
        while (!ctl_ready) @(negedge clk);
        wlog_a.delete(); wlog_d.delete(); kind_q.delete();
        cpu_req = 1'b1; cpu_we = we; cpu_addr = AW'(a); cpu_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        cpu_req = 1'b0;
        cyc = 1;
        while (nrdy < need && cyc < 200) begin
            if (cpu_rdy) begin
                got[nrdy] = cpu_rdata;
                at[nrdy] = cyc;
                nrdy++;
            end
            if (nrdy < need) begin
                @(negedge clk);
                cyc++;
            end
        end
        @(negedge clk);
        chk(nrdy == need, req, "completed words", nrdy, need);
        if (!we)
            for (int w = 0; w < 4; w++) chk(got[w] === exp_d[w], req, "read word", got[w], exp_d[w]);
        if (hit)
            for (int w = 0; w < need; w++)
                chk(at[w] == w + 2, we ? "R3" : "R2", "ready cycle", at[w], w + 2);
        foreach (kind_q[i]) if (!kind_q[i]) rc++;
        chk(rc == exp_rd, "R11", "memory word reads", rc, exp_rd);
        chk(wlog_a.size() == exp_wa.size(), we ? "R7" : "R6", "memory writes", wlog_a.size(), exp_wa.size());
        foreach (exp_wa[i]) if (i < wlog_a.size()) begin
            chk(wlog_a[i] == exp_wa[i], "R4", "write address", wlog_a[i], exp_wa[i]);
            chk(wlog_d[i] === exp_wd[i], "R4", "write data", wlog_d[i], exp_wd[i]);
        end
        foreach (kind_q[i]) chk(kind_q[i] == (i < exp_wa.size()), "R4", "write-back order", kind_q[i], i < exp_wa.size());
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int cnt;
        bit stray;
        repeat (3) @(negedge clk);
        chk(ctl_ready == 0 && cpu_rdy == 0 && mem_req == 0, "R9", "outputs in reset",
            {ctl_ready, cpu_rdy, mem_req}, 0);
        rst = 1'b0;
        cnt = 0;
        do begin @(posedge clk); @(negedge clk); cnt++; end while (!ctl_ready && cnt < 1000);
        chk(cnt == N, "R9", "sweep length after reset", cnt, N);

        access(0, 32'h0040, 0, "R5");           // cold read miss
        access(0, 32'h0040, 0, "R2");           // read hit
        access(1, 32'h0044, 32'hAAAA_0001, "R3");// write hit
        access(0, 32'h0040, 0, "R2 R3");        // hit sees new word
        access(0, 32'h0440, 0, "R1 R4 R5");     // dirty eviction, same index
        access(0, 32'h0040, 0, "R6");           // clean eviction
        access(1, 32'h0100, 32'hBBBB_0002, "R7");// write miss, no allocation
        access(0, 32'h0100, 0, "R7 R5");        // still a miss, new data from memory
        access(0, 32'h0840, 0, "R8 R1");        // non-cacheable read, aliases index 4
        access(0, 32'h0840, 0, "R8");           // again from memory
        access(0, 32'h0040, 0, "R8 R2");        // entry 4 untouched
        access(1, 32'h0848, 32'hCCCC_0003, "R8");// non-cacheable write
        access(0, 32'hF040, 0, "R8 R1");        // top bits set
        access(1, 32'h0048, 32'hDDDD_0004, "R3");// make line dirty

        // flush wins over a simultaneous request; requests during the sweep are ignored
        flush = 1'b1; cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 16'h0100;
        wlog_a.delete(); kind_q.delete();
        @(posedge clk); @(negedge clk);
        flush = 1'b0; cpu_req = 1'b0;
        stray = 0; cnt = 0;
        do begin
            stray |= cpu_rdy | mem_req;
            cpu_req = (cnt == 3);
            @(posedge clk); @(negedge clk); cnt++;
        end while (!ctl_ready && cnt < 1000);
        cpu_req = 1'b0;
        chk(cnt == N, "R9", "sweep length after flush", cnt, N);
        repeat (3) begin stray |= cpu_rdy | mem_req; @(negedge clk); end
        chk(!stray && kind_q.size() == 0, "R10", "request during flush ignored", stray, 0);
        for (int i = 0; i < N; i++) rv[i] = 0;
        access(0, 32'h0040, 0, "R9");           // dirty word discarded, refetched

        for (int k = 0; k < 80; k++) begin
            int tg = $urandom % 9;
            int a = (tg << 8) | (($urandom % 4) << 4) | (($urandom % 4) << 2);
            access(($urandom % 3) == 0, a, $urandom, "R1");
        end
        finish_run();
    end
endmodule